// File: doc/BRIEF.md
# Line Latch with Polarity and Output Control

This block sits between the line capture stage and the output stage of a column driver. It holds one complete line of gray codes, one code per output, and decides when a new line takes effect, when the outputs are released from high impedance, and which reference bank (low or high) each output uses. A strobe pulse, one per horizontal line period, controls the sequence. The rising edge of the strobe copies the captured line into the latch and turns the outputs off. The falling edge turns them back on, driven from the latched codes.

The polarity input is sampled at the strobe rising edge. It decides whether odd-numbered outputs take the low bank and even-numbered outputs the high bank, or the reverse. Both strobe edges are found synchronously on the block clock, so every update happens one clock after the edge is first sampled. A one-cycle overrun pulse reports a load that arrives before the capture stage has signalled that a new line is complete.

Top module: `line_latch`

## Requirements
- R1: After reset, out_en_o is 0, every code in codes_o is 0, overrun_o is 0, and bank_sel_o matches polarity 0 (see R6).
- R2: If strobe_i is first sampled high at clock edge k, then at edge k+1 codes_o takes the value of line_data_i present at that edge. Output i occupies bits [i*CODE_W +: CODE_W].
- R3: out_en_o goes to 0 at edge k+1 (with k as in R2) and stays 0 for as long as strobe_i is high.
- R4: If strobe_i is first sampled low at edge m after a high period, out_en_o becomes 1 at edge m+1, and codes_o keeps its value.
- R5: Between two loads, codes_o ignores every change of line_data_i.
- R6: bank_sel_o[i] = P XOR (i mod 2), where P is the captured polarity and 0 selects the low bank. With 0-based index i, an even i is an odd-numbered output.
- R7: The polarity is captured only at the load edge (k+1). Changes of pol_i at any other time do not alter bank_sel_o.
- R8: At a load edge, overrun_o pulses to 1 for one clock if line_done_i has not been sampled high since the previous load edge. The load still takes place. The first load after reset never raises it.
- R9: A line_done_i that is high at the load edge counts toward the next line, not the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Line strobe; its rising edge loads, its falling edge releases |
| pol_i | input | 1 | Polarity request, captured at the load |
| line_done_i | input | 1 | High when the capture stage has finished a line |
| line_data_i | input | NUM_OUT*CODE_W | Captured line from the capture stage |
| codes_o | output | NUM_OUT*CODE_W | Latched gray codes |
| bank_sel_o | output | NUM_OUT | Reference bank per output, 1 = high bank |
| out_en_o | output | 1 | 1 = outputs driven, 0 = high impedance |
| overrun_o | output | 1 | One-cycle pulse: load before line completion |

## Verification
The bench runs sixteen lines through a small configuration. Each line has its own arithmetic code pattern and polarity, and some lines skip the completion signal. A design that loaded on the falling edge, or that sampled the line late, would show the bench the data changed while the strobe was high, not the data present at the load edge. Polarity and data are both changed while the strobe is high, so a design that tracked pol_i live or kept copying the line would alter the outputs after the load. The skipped completions, the exempt first load and the completion coincident with a load catch an overrun flag that is sticky, mis-timed or credited to the wrong line.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } strb_evt_t;
endpackage

// File: rtl/lat_edge_det.sv
module lat_edge_det
  import lat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_i,
  output strb_evt_t evt_o
);
  logic smp_q, smp_d;
  logic smp_q_nxt, smp_d_nxt;

  always_comb begin
    smp_q_nxt = strobe_i;
    smp_d_nxt = smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      smp_d <= 1'b0;
    end else begin
      smp_q <= smp_q_nxt;
      smp_d <= smp_d_nxt;
    end
  end

  always_comb begin
    evt_o.rise = smp_q & ~smp_d;
    evt_o.fall = ~smp_q & smp_d;
  end
endmodule

// File: rtl/lat_code_bank.sv
module lat_code_bank #(
  parameter int NUM_OUT = 384,
  parameter int CODE_W  = 6,
  localparam int BUS_W  = NUM_OUT * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [BUS_W-1:0] codes_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_seg
    logic [CODE_W-1:0] seg_q, seg_nxt;

    always_comb begin
      seg_nxt = seg_q;
      if (load_i) seg_nxt = data_i[g*CODE_W +: CODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q <= '0;
      else        seg_q <= seg_nxt;
    end

    assign codes_o[g*CODE_W +: CODE_W] = seg_q;
  end
endmodule

// File: rtl/lat_bank_map.sv
module lat_bank_map #(
  parameter int NUM_OUT = 384
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               pol_i,
  output logic [NUM_OUT-1:0] bank_sel_o
);
  logic pol_q, pol_nxt;

  always_comb begin
    pol_nxt = pol_q;
    if (load_i) pol_nxt = pol_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= 1'b0;
    else        pol_q <= pol_nxt;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_bank
    if ((g % 2) == 0) begin : g_odd_pin
      assign bank_sel_o[g] = pol_q;
    end else begin : g_even_pin
      assign bank_sel_o[g] = ~pol_q;
    end
  end
endmodule

// File: rtl/line_latch.sv
module line_latch
  import lat_pkg::*;
#(
  parameter int NUM_OUT = 384,
  parameter int CODE_W  = 6,
  localparam int BUS_W  = NUM_OUT * CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_i,
  input  logic               pol_i,
  input  logic               line_done_i,
  input  logic [BUS_W-1:0]   line_data_i,
  output logic [BUS_W-1:0]   codes_o,
  output logic [NUM_OUT-1:0] bank_sel_o,
  output logic               out_en_o,
  output logic               overrun_o
);
  strb_evt_t evt;
  logic en_q, en_nxt;
  logic ready_q, ready_nxt;
  logic ovr_q, ovr_nxt;

  lat_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .evt_o    (evt)
  );

  lat_code_bank #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) u_codes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (evt.rise),
    .data_i  (line_data_i),
    .codes_o (codes_o)
  );

  lat_bank_map #(.NUM_OUT(NUM_OUT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (evt.rise),
    .pol_i      (pol_i),
    .bank_sel_o (bank_sel_o)
  );

  always_comb begin
    en_nxt    = en_q;
    ready_nxt = ready_q;
    ovr_nxt   = 1'b0;
    if (evt.rise) begin
      en_nxt    = 1'b0;
      ovr_nxt   = ~ready_q;
      ready_nxt = line_done_i;
    end else begin
      if (evt.fall)    en_nxt    = 1'b1;
      if (line_done_i) ready_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ready_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      en_q    <= en_nxt;
      ready_q <= ready_nxt;
      ovr_q   <= ovr_nxt;
    end
  end

  assign out_en_o  = en_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/lat_chk.sv
module lat_chk #(
  parameter int NUM_OUT = 384,
  parameter int CODE_W  = 6,
  localparam int BUS_W  = NUM_OUT * CODE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rise,
  input logic               fall,
  input logic               strobe_i,
  input logic [BUS_W-1:0]   line_data_i,
  input logic [BUS_W-1:0]   codes_o,
  input logic [NUM_OUT-1:0] bank_sel_o,
  input logic               out_en_o,
  input logic               overrun_o
);
  AST_LOAD_TAKES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> codes_o == $past(line_data_i)); // R2

  AST_OFF_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !out_en_o); // R3

  AST_OFF_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe_i) && strobe_i && !rise) |=> !out_en_o); // R3

  AST_ON_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> out_en_o); // R4

  AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(codes_o)); // R5

  AST_BANK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel_o[0] != bank_sel_o[1]); // R6

  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(bank_sel_o)); // R7

  AST_OVR_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(rise)); // R8

  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> !overrun_o); // R8
endmodule

bind line_latch lat_chk #(.NUM_OUT(NUM_OUT), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rise        (evt.rise),
  .fall        (evt.fall),
  .strobe_i    (strobe_i),
  .line_data_i (line_data_i),
  .codes_o     (codes_o),
  .bank_sel_o  (bank_sel_o),
  .out_en_o    (out_en_o),
  .overrun_o   (overrun_o)
);

// File: tb/sim_line_latch.sv
module sim_line_latch;
  localparam int NO = 8;
  localparam int CW = 3;
  localparam int BW = NO * CW;

  logic clk, rst_n, strobe, pol, done;
  logic [BW-1:0] data, codes;
  logic [NO-1:0] bank;
  logic en, ovr;
  int checks, errors;
  bit finished;

  line_latch #(.NUM_OUT(NO), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .pol_i(pol),
    .line_done_i(done), .line_data_i(data), .codes_o(codes),
    .bank_sel_o(bank), .out_en_o(en), .overrun_o(ovr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [BW-1:0] mk_line(int n);
    logic [BW-1:0] v;
    for (int i = 0; i < NO; i++) v[i*CW +: CW] = CW'((i*3 + n*5 + i*n) % (1 << CW));
    return v;
  endfunction

  function automatic logic [NO-1:0] mk_bank(logic p);
    logic [NO-1:0] v;
    for (int i = 0; i < NO; i++) v[i] = p ^ i[0];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ready, exp_ovr, p;
    logic [BW-1:0] held;
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; strobe = 1'b0; pol = 1'b0; done = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(en == 1'b0, "R1 out_en", 64'(en), 0);
    chk(codes == '0, "R1 codes", 64'(codes), 0);
    chk(ovr == 1'b0, "R1 overrun", 64'(ovr), 0);
    chk(bank == mk_bank(1'b0), "R1 bank", 64'(bank), 64'(mk_bank(1'b0)));

    ready = 1'b1;
    for (int n = 0; n < 16; n++) begin
      bit give_done = (n != 0) && (n != 5) && (n != 11) && (n != 12);
      bit done_at_load = (n == 11);
      p = n[0] ^ n[2];
      if (give_done) begin
        done = 1'b1; step(); done = 1'b0; ready = 1'b1;
      end
      data = mk_line(n);
      pol = p;
      strobe = 1'b1;
      step();                  // edge k samples strobe high
      if (n > 0) chk(en == 1'b1, "R3 en before load edge", 64'(en), 1);
      done = done_at_load;
      @(posedge clk);          // edge k+1: load
      @(negedge clk);
      done = 1'b0;
      exp_ovr = ~ready;
      ready = done_at_load;
      chk(codes == mk_line(n), "R2 codes loaded", 64'(codes), 64'(mk_line(n)));
      chk(bank == mk_bank(p), "R6 bank map", 64'(bank), 64'(mk_bank(p)));
      chk(en == 1'b0, "R3 disabled on load", 64'(en), 0);
      chk(ovr == exp_ovr, "R8 overrun at load", 64'(ovr), 64'(exp_ovr));
      // change polarity and data after the load
      held = mk_line(n);
      pol = ~p;
      data = ~mk_line(n);
      step();
      chk(ovr == 1'b0, "R8 one-cycle pulse", 64'(ovr), 0);
      step();
      chk(en == 1'b0, "R3 disabled while high", 64'(en), 0);
      chk(codes == held, "R5 codes held", 64'(codes), 64'(held));
      chk(bank == mk_bank(p), "R7 polarity held", 64'(bank), 64'(mk_bank(p)));
      strobe = 1'b0;
      step();                  // edge m samples low
      chk(en == 1'b0, "R4 not yet released", 64'(en), 0);
      step();                  // edge m+1
      chk(en == 1'b1, "R4 released", 64'(en), 1);
      chk(codes == held, "R4 codes kept", 64'(codes), 64'(held));
      pol = p;
      data = mk_line(n + 7);
      step();
      chk(codes == held, "R5 data ignored between loads", 64'(codes), 64'(held));
      chk(bank == mk_bank(p), "R7 pol ignored between loads", 64'(bank), 64'(mk_bank(p)));
      if (n == 12) chk(ovr == 1'b0, "R9 coincident done credited", 64'(ovr), 0);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule